// File: doc/BRIEF.md
# Bit-Field Extract Execution Unit

This unit executes two custom instructions that pull a narrow field, 1 to 8 bits wide, out of a 32-bit source operand and return it zero-extended in the destination. Both instructions sit in the custom-0 major opcode. The register form reads the start bit position from the low five bits of the second source operand. The immediate form carries the start position inside the instruction word. In both forms a 3-bit code in the instruction gives the field width minus one.

Each cycle the core presents an instruction word, the two operand values and an issue strobe. One clock later the unit reports whether it recognised and accepted the instruction, whether the instruction was one of its own but used a reserved encoding, a destination write enable, the destination register index and the extracted value. All outputs are registered, so the extract path forms one pipeline stage. The register file and hazard logic stay in the surrounding core.

Top module: `bfx_unit`

## Requirements
- R1: While `rst` is high at a clock edge, every output is zero on the following cycle.
- R2: Register form: opcode bits [6:0] = 0x0B, funct3 bits [14:12] = 0, width code in bits [28:26], shift amount taken from `rs2_val[4:0]`; an issued legal instruction raises `match` exactly one cycle later.
- R3: Immediate form: opcode bits [6:0] = 0x0B, funct3 bits [14:12] = 4, width code in bits [28:26], shift amount in bits [24:20]; an issued legal instruction raises `match` exactly one cycle later.
- R4: For a matched instruction, with width code c and shift s, `rd_data` = (`rs1_val` logically shifted right by s) AND (2^(c+1) − 1); every bit above bit c is zero. Widths 1..8 and shifts 0..31 are all legal.
- R5: In the register form, bits [31:5] of `rs2_val` have no effect on the result.
- R6: An instruction with opcode 0x0B and funct3 0 or 4 but any of bits [31:29] or bit [25] set is reserved: `illegal` is 1 and `match`, `wr_en`, `rd_idx` and `rd_data` are 0.
- R7: When the destination index (bits [11:7]) is 0, a legal instruction still raises `match` and delivers `rd_data`, but `wr_en` stays 0; otherwise `wr_en` equals `match`.
- R8: An instruction with a different opcode, or opcode 0x0B with a funct3 other than 0 or 4, leaves all outputs zero.
- R9: A cycle with `issue` low leaves all outputs zero on the next cycle, whatever the instruction word.
- R10: For a matched instruction `rd_idx` equals instruction bits [11:7].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | Instruction word and operands are valid this cycle |
| instr | input | 32 | Instruction word |
| rs1_val | input | 32 | First source operand (data to extract from) |
| rs2_val | input | 32 | Second source operand (shift amount in register form) |
| match | output | 1 | A legal extract instruction was executed last cycle |
| illegal | output | 1 | A reserved encoding of an extract instruction was seen last cycle |
| wr_en | output | 1 | Destination write enable |
| rd_idx | output | 5 | Destination register index |
| rd_data | output | 32 | Extracted, zero-extended field |

## Verification
On every cycle the assertions check that `illegal` and `match` never coincide, that a write enable implies a match to a nonzero register, that no result bit above the widest field is ever set, that an idle cycle produces no flags and that a decoded legal issue is followed by `match`. The exact field value for every width and shift, the indifference to the upper bits of the second operand, the x0 write suppression and the rejection of foreign opcodes can only be shown by the bench's scenarios, which compare each result with a software model of the extract.

// File: rtl/bfx_pkg.sv
`timescale 1ns/1ps
package bfx_pkg;
  localparam int ILEN    = 32;
  localparam int WCODE_W = 3;
  localparam int SHAMT_W = 5;
  localparam int REG_W   = 5;
  localparam int FIELD_MAX = 1 << WCODE_W;

  localparam logic [6:0] OPC_CUSTOM0 = 7'h0B;
  localparam logic [2:0] F3_REGFORM  = 3'd0;
  localparam logic [2:0] F3_IMMFORM  = 3'd4;

  typedef enum logic [1:0] {
    FORM_NONE = 2'd0,
    FORM_REG  = 2'd1,
    FORM_IMM  = 2'd2
  } form_e;

  typedef struct packed {
    form_e                form;
    logic                 legal;
    logic [WCODE_W-1:0]   wcode;
    logic [SHAMT_W-1:0]   shamt;
    logic [REG_W-1:0]     rd;
  } dec_t;
endpackage

// File: rtl/bfx_decode.sv
`timescale 1ns/1ps
module bfx_decode
  import bfx_pkg::*;
(
  input  logic [ILEN-1:0] instr,
  output dec_t            dec
);
  logic opc_hit;
  logic f3_reg;
  logic f3_imm;
  logic rsv_reg;
  logic rsv_imm;
  logic unused_rs1_idx;

  assign unused_rs1_idx = ^instr[19:15];

  always_comb begin
    opc_hit = (instr[6:0] == OPC_CUSTOM0);
    f3_reg  = (instr[14:12] == F3_REGFORM);
    f3_imm  = (instr[14:12] == F3_IMMFORM);
    // funct7 upper three bits and its lowest bit are reserved
    rsv_reg = (|instr[31:29]) | instr[25];
    // immediate bits [11:9] and bit 5 are reserved
    rsv_imm = (|instr[31:29]) | instr[25];

    if (opc_hit && f3_reg)      dec.form = FORM_REG;
    else if (opc_hit && f3_imm) dec.form = FORM_IMM;
    else                        dec.form = FORM_NONE;

    dec.legal = ((dec.form == FORM_REG) && !rsv_reg) ||
                ((dec.form == FORM_IMM) && !rsv_imm);
    dec.wcode = instr[28:26];
    dec.shamt = instr[24:20];
    dec.rd    = instr[11:7];
  end
endmodule

// File: rtl/bfx_extract.sv
`timescale 1ns/1ps
module bfx_extract #(
  parameter int XLEN = 32,
  parameter int SH_W = 5,
  parameter int WC_W = 3
) (
  input  logic [XLEN-1:0] src,
  input  logic [SH_W-1:0] sh,
  input  logic [WC_W-1:0] wcode,
  output logic [XLEN-1:0] field
);
  localparam int FMAX = 1 << WC_W;

  logic [XLEN-1:0] stage [SH_W+1];
  logic [XLEN-1:0] mask;

  assign stage[0] = src;

  // logarithmic shifter: one stage per shift-amount bit
  for (genvar k = 0; k < SH_W; k++) begin : g_shift
    assign stage[k+1] = sh[k] ? (stage[k] >> (1 << k)) : stage[k];
  end

  // thermometer mask: bit i set when i <= wcode
  for (genvar i = 0; i < XLEN; i++) begin : g_mask
    if (i < FMAX) begin : g_live
      assign mask[i] = (WC_W'(i) <= wcode);
    end else begin : g_dead
      assign mask[i] = 1'b0;
    end
  end

  assign field = stage[SH_W] & mask;
endmodule

// File: rtl/bfx_unit.sv
`timescale 1ns/1ps
module bfx_unit
  import bfx_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue,
  input  logic [ILEN-1:0]  instr,
  input  logic [XLEN-1:0]  rs1_val,
  input  logic [XLEN-1:0]  rs2_val,
  output logic             match,
  output logic             illegal,
  output logic             wr_en,
  output logic [REG_W-1:0] rd_idx,
  output logic [XLEN-1:0]  rd_data
);
  dec_t               dec;
  logic [SHAMT_W-1:0] shift_sel;
  logic [XLEN-1:0]    field;
  logic               accept;
  logic               reject;
  logic               unused_rs2_hi;

  assign unused_rs2_hi = ^rs2_val[XLEN-1:SHAMT_W];

  bfx_decode u_dec (
    .instr (instr),
    .dec   (dec)
  );

  assign shift_sel = (dec.form == FORM_REG) ? rs2_val[SHAMT_W-1:0] : dec.shamt;

  bfx_extract #(
    .XLEN (XLEN),
    .SH_W (SHAMT_W),
    .WC_W (WCODE_W)
  ) u_ext (
    .src   (rs1_val),
    .sh    (shift_sel),
    .wcode (dec.wcode),
    .field (field)
  );

  assign accept = issue && dec.legal;
  assign reject = issue && (dec.form != FORM_NONE) && !dec.legal;

  always_ff @(posedge clk) begin
    if (rst) begin
      match   <= 1'b0;
      illegal <= 1'b0;
      wr_en   <= 1'b0;
      rd_idx  <= '0;
      rd_data <= '0;
    end else begin
      match   <= accept;
      illegal <= reject;
      wr_en   <= accept && (dec.rd != '0);
      rd_idx  <= accept ? dec.rd : '0;
      rd_data <= accept ? field  : '0;
    end
  end

  p_flags_excl_r6: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!match && !wr_en && rd_data == '0));

  p_we_nonzero_r7: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (match && rd_idx != '0));

  p_high_zero_r4: assert property (@(posedge clk) disable iff (rst)
    rd_data[XLEN-1:FIELD_MAX] == '0);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !issue |=> (!match && !illegal && !wr_en));

  p_latency_r3: assert property (@(posedge clk) disable iff (rst)
    (issue && dec.legal) |=> match);
endmodule

// File: tb/sim_bfx_unit.sv
`timescale 1ns/1ps
module sim_bfx_unit;
  import bfx_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issue = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] rs1_val = '0;
  logic [31:0] rs2_val = '0;
  logic        match, illegal, wr_en;
  logic [4:0]  rd_idx;
  logic [31:0] rd_data;

  bfx_unit u0 (
    .clk(clk), .rst(rst), .issue(issue), .instr(instr),
    .rs1_val(rs1_val), .rs2_val(rs2_val),
    .match(match), .illegal(illegal), .wr_en(wr_en),
    .rd_idx(rd_idx), .rd_data(rd_data)
  );

  always #10 clk = ~clk;

  typedef struct {
    logic        m;
    logic        il;
    logic        we;
    logic [4:0]  rd;
    logic [31:0] d;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   mon_on = 1'b0;

  function automatic logic [31:0] enc_reg(input logic [2:0] wc, input logic [4:0] rd);
    return {3'b000, wc, 1'b0, 5'd2, 5'd1, F3_REGFORM, rd, OPC_CUSTOM0};
  endfunction

  function automatic logic [31:0] enc_imm(input logic [2:0] wc, input logic [4:0] sh,
                                          input logic [4:0] rd);
    return {3'b000, wc, 1'b0, sh, 5'd1, F3_IMMFORM, rd, OPC_CUSTOM0};
  endfunction

  function automatic logic [31:0] model(input logic [31:0] a, input int sh, input int w);
    return (a >> sh) & ((32'h1 << w) - 32'h1);
  endfunction

  function automatic exp_t e_ok(input logic [4:0] rd, input logic [31:0] d, input string tag);
    exp_t e;
    e.m = 1'b1; e.il = 1'b0; e.we = (rd != 5'd0); e.rd = rd; e.d = d; e.tag = tag;
    return e;
  endfunction

  function automatic exp_t e_none(input logic il, input string tag);
    exp_t e;
    e.m = 1'b0; e.il = il; e.we = 1'b0; e.rd = 5'd0; e.d = '0; e.tag = tag;
    return e;
  endfunction

  task automatic drive(input logic iss, input logic [31:0] ins,
                       input logic [31:0] a, input logic [31:0] b, input exp_t e);
    @(negedge clk);
    issue = iss; instr = ins; rs1_val = a; rs2_val = b;
    sb.push_back(e);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // monitor: one expected item per driven cycle, compared after the edge
  initial begin
    forever begin
      exp_t e;
      @(posedge clk);
      #2;
      if (mon_on && sb.size() > 0) begin
        e = sb.pop_front();
        n_chk++;
        if ({match, illegal, wr_en, rd_idx, rd_data} !== {e.m, e.il, e.we, e.rd, e.d}) begin
          n_fail++;
          $display("FAIL %s: got m=%0d il=%0d we=%0d rd=%0d d=%h, expected m=%0d il=%0d we=%0d rd=%0d d=%h",
                   e.tag, match, illegal, wr_en, rd_idx, rd_data,
                   e.m, e.il, e.we, e.rd, e.d);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, got timeout, expected completion");
    summary();
    $finish;
  end

  initial begin
    // R1: reset clears everything, even with an issued legal instruction
    issue = 1'b1; instr = enc_imm(3'd7, 5'd0, 5'd3); rs1_val = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    n_chk++;
    if ({match, illegal, wr_en, rd_idx, rd_data} !== '0) begin
      n_fail++;
      $display("FAIL R1: got m=%0d il=%0d we=%0d rd=%0d d=%h, expected all zero",
               match, illegal, wr_en, rd_idx, rd_data);
    end
    issue = 1'b0;
    rst = 1'b0;
    mon_on = 1'b1;

    // sweep of every width and shift in both forms (R2, R3, R4, R5, R10)
    for (int w = 1; w <= 8; w++) begin
      for (int sh = 0; sh < 32; sh++) begin
        for (int k = 0; k < 2; k++) begin
          logic [31:0] a;
          logic [31:0] b;
          logic [4:0]  rd;
          a  = $urandom;
          rd = 5'($urandom_range(1, 31));
          drive(1'b1, enc_imm(3'(w - 1), 5'(sh), rd), a, $urandom,
                e_ok(rd, model(a, sh, w), "R3_R4_R10 imm sweep"));
          a  = $urandom;
          b  = {27'($urandom), 5'(sh)};
          drive(1'b1, enc_reg(3'(w - 1), rd), a, b,
                e_ok(rd, model(a, sh, w), "R2_R4_R5 reg sweep"));
        end
      end
    end

    // R4 boundaries
    drive(1'b1, enc_imm(3'd7, 5'd31, 5'd4), 32'hFFFF_FFFF, '0,
          e_ok(5'd4, 32'h1, "R4 top bit only"));
    drive(1'b1, enc_imm(3'd7, 5'd0, 5'd4), 32'h1234_5678, '0,
          e_ok(5'd4, 32'h78, "R4 low byte"));
    drive(1'b1, enc_reg(3'd0, 5'd9), 32'h0000_0020, 32'd5,
          e_ok(5'd9, 32'h1, "R4 single bit"));
    drive(1'b1, enc_imm(3'd7, 5'd28, 5'd4), 32'hF000_0000, '0,
          e_ok(5'd4, 32'hF, "R4 field past msb"));

    // R5: upper rs2 bits all set, shift = 3
    drive(1'b1, enc_reg(3'd3, 5'd6), 32'h0000_0AB8, 32'hFFFF_FFE3,
          e_ok(5'd6, 32'h7, "R5 rs2 upper ignored"));

    // R6: reserved bits
    drive(1'b1, enc_imm(3'd2, 5'd1, 5'd5) | 32'h2000_0000, $urandom, '0,
          e_none(1'b1, "R6 imm bit29"));
    drive(1'b1, enc_imm(3'd2, 5'd1, 5'd5) | 32'h0200_0000, $urandom, '0,
          e_none(1'b1, "R6 imm bit25"));
    drive(1'b1, enc_reg(3'd2, 5'd5) | 32'h8000_0000, $urandom, 32'd1,
          e_none(1'b1, "R6 reg bit31"));
    drive(1'b1, enc_reg(3'd2, 5'd5) | 32'h4000_0000, $urandom, 32'd1,
          e_none(1'b1, "R6 reg bit30"));

    // R7: destination x0
    drive(1'b1, enc_imm(3'd3, 5'd4, 5'd0), 32'h0000_0350, '0,
          e_ok(5'd0, 32'h5, "R7 imm rd zero"));
    drive(1'b1, enc_reg(3'd7, 5'd0), 32'hA5A5_A5A5, 32'd8,
          e_ok(5'd0, 32'hA5, "R7 reg rd zero"));

    // R8: foreign encodings
    drive(1'b1, (enc_imm(3'd7, 5'd0, 5'd3) & ~32'h7F) | 32'h33, 32'hFFFF_FFFF, '0,
          e_none(1'b0, "R8 other opcode"));
    drive(1'b1, (enc_imm(3'd7, 5'd0, 5'd3) & ~32'h7000) | 32'h5000, 32'hFFFF_FFFF, '0,
          e_none(1'b0, "R8 other funct3"));

    // R9: not issued
    drive(1'b0, enc_imm(3'd7, 5'd0, 5'd3), 32'hFFFF_FFFF, '0,
          e_none(1'b0, "R9 idle legal word"));
    drive(1'b0, enc_imm(3'd7, 5'd0, 5'd3) | 32'h2000_0000, 32'hFFFF_FFFF, '0,
          e_none(1'b0, "R9 idle reserved word"));

    // back-to-back after idle
    drive(1'b1, enc_reg(3'd1, 5'd31), 32'h0000_000C, 32'd2,
          e_ok(5'd31, 32'h3, "R2_R10 after idle"));

    @(negedge clk);
    issue = 1'b0;
    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule